// File: doc/BRIEF.md
# Ordered Supply-Rail Power Sequencer

This controller brings up and shuts down the five supply rails of an attached device in a fixed order. For each rail it drives the regulator enable pin and then waits for that rail's power-good input to reach the expected level. Each wait is bounded by a timeout. When all five rails are up, the controller raises an all-rails-good output. After a settle delay it releases the device's active-low reset.

A power-on request starts the up sequence, and a power-off request starts the down sequence. Power-down first asserts reset and waits for a hold delay. It then drops all-rails-good and turns the rails off from the last rail to the first. If a rail times out while powering up, the controller runs a complete power-down and reports an error together with the failing rail. If a rail does not turn off during power-down, the controller records the error and moves on to the next rail.

Rail 2 has an active-low enable pin. Its power-good input is also compared against the inverted level. All delays count in microseconds from a tick whose clocks-per-microsecond is a parameter, so a simulation can compress the time scale.

Top module: `rail_seq_ctrl`

## Requirements
- R1: On power-up, rails turn on one at a time in index order 0,1,2,3,4. A rail's enable is driven only after the previous rail's power-good has matched its on level.
- R2: A rail wait fails when power-good has not matched after TIMEOUT_US microseconds. The failure is seen TIMEOUT_US*CLKS_PER_US+1 clocks after that rail's enable changed.
- R3: Rail 2 (index 2) has an inverted enable pin, low when on and high when off. Its power-good is also active-low. All other rails use active-high enable and power-good.
- R4: Accepting a power-on request drives dev_rst_n low. rails_good rises one clock after the last rail reports good. dev_rst_n rises GOOD_WAIT_US*CLKS_PER_US+1 clocks after rails_good rises.
- R5: If a rail times out during power-up, the controller sets error and sets fail_rail to that rail's index. It then performs the full power-down, and it never raises rails_good or dev_rst_n in that sequence.
- R6: Power-down drives dev_rst_n low and drops rails_good RST_HOLD_US*CLKS_PER_US+1 clocks later. It then turns the rails off in order 4,3,2,1,0.
- R7: During power-down, a rail that stays on past the timeout sets error and sequencing continues with the next rail. fail_rail holds the first rail that failed.
- R8: A power-off request is ignored unless the last power-up fully succeeded. A power-on request is ignored while that status is set.
- R9: Requests that arrive while busy is high are ignored. busy is high from the clock after acceptance until the sequence ends, and it falls exactly once per sequence.
- R10: done, error and fail_rail clear when a new sequence is accepted. done is set when a sequence ends.
- R11: After reset, all rails are logically off (rail_en equals the polarity mask 5'b00100), rails_good=0, dev_rst_n=0, and busy, done, error and fail_rail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Request power-up sequence |
| pwr_off_req | input | 1 | Request power-down sequence |
| rail_pg | input | NUM_RAILS | Regulator power-good pins |
| rail_en | output | NUM_RAILS | Regulator enable pins (polarity per INV_MASK) |
| rails_good | output | 1 | All-rails-good indication to the device |
| dev_rst_n | output | 1 | Active-low device reset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last sequence finished |
| error | output | 1 | A rail timed out in the last sequence |
| fail_rail | output | $clog2(NUM_RAILS) | Index of the first rail that timed out |

## Verification
A wrong state or rail index appears on rail_en within a clock, either as a second enable moving or as a rail moving out of order. An off-by-one in the microsecond timer shifts the rise of rails_good, dev_rst_n or error by at least one clock against the bench model. A lost first-failure record shows up on fail_rail when a later rail also fails during power-down. The model is compared with every output on every clock, so any divergence is reported in the cycle where it first appears.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UP_EN,
    S_UP_WAIT,
    S_UP_GOOD,
    S_DN_HOLD,
    S_DN_EN,
    S_DN_WAIT
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rail_us_timer.sv
module rail_us_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] us_cnt;
  logic             tick;

  assign tick    = (pre_cnt == PRE_LAST);
  assign expired = (us_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pre_cnt <= '0;
      us_cnt  <= '0;
    end else if (!expired) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) us_cnt <= us_cnt + 1'b1;
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_LAST); // R2

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (us_cnt == '0)); // R2

endmodule

// File: rtl/rail_pin_map.sv
module rail_pin_map #(
  parameter int                      NUM_RAILS = 5,
  parameter logic [NUM_RAILS-1:0]    INV_MASK  = 5'b00100
) (
  input  logic [NUM_RAILS-1:0] en_log,
  input  logic [NUM_RAILS-1:0] pg_pin,
  output logic [NUM_RAILS-1:0] en_pin,
  output logic [NUM_RAILS-1:0] pg_log
);

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    if (INV_MASK[i]) begin : g_low
      assign en_pin[i] = ~en_log[i];
      assign pg_log[i] = ~pg_pin[i];
    end else begin : g_high
      assign en_pin[i] = en_log[i];
      assign pg_log[i] = pg_pin[i];
    end
  end

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int NUM_RAILS    = 5,
  parameter int IDX_W        = 3,
  parameter int CNT_W        = 16,
  parameter int TIMEOUT_US   = 20000,
  parameter int RST_HOLD_US  = 5000,
  parameter int GOOD_WAIT_US = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 on_req,
  input  logic                 off_req,
  input  logic [NUM_RAILS-1:0] pg_log,
  input  logic                 expired,
  output logic                 tmr_start,
  output logic [CNT_W-1:0]     tmr_limit,
  output logic [NUM_RAILS-1:0] en_log,
  output logic                 all_good,
  output logic                 rst_n,
  output logic                 busy,
  output logic                 done,
  output logic                 error,
  output logic [IDX_W-1:0]     fail_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RAILS - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] rail_idx;
  logic             powered;
  logic             pg_sel;
  logic             last;
  logic             on_go;
  logic             off_go;

  assign pg_sel = pg_log[rail_idx];
  assign last   = (rail_idx == LAST_IDX);
  assign on_go  = on_req && !powered;
  assign off_go = off_req && powered && !on_go;

  always_comb begin
    case (state)
      S_DN_HOLD: tmr_limit = CNT_W'(RST_HOLD_US);
      S_UP_GOOD: tmr_limit = CNT_W'(GOOD_WAIT_US);
      default:   tmr_limit = CNT_W'(TIMEOUT_US);
    endcase
  end

  always_comb begin
    case (state)
      S_IDLE:    tmr_start = off_go;
      S_UP_EN:   tmr_start = 1'b1;
      S_DN_EN:   tmr_start = 1'b1;
      S_UP_WAIT: tmr_start = (pg_sel && last) || (!pg_sel && expired);
      default:   tmr_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rail_idx <= '0;
      en_log   <= '0;
      all_good <= 1'b0;
      rst_n    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      fail_idx <= '0;
      powered  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (on_go) begin
            state    <= S_UP_EN;
            rail_idx <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            fail_idx <= '0;
            rst_n    <= 1'b0;
          end else if (off_go) begin
            state    <= S_DN_HOLD;
            busy     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            fail_idx <= '0;
            rst_n    <= 1'b0;
            powered  <= 1'b0;
          end
        end
        S_UP_EN: begin
          en_log[rail_idx] <= 1'b1;
          state            <= S_UP_WAIT;
        end
        S_UP_WAIT: begin
          if (pg_sel) begin
            if (last) begin
              all_good <= 1'b1;
              state    <= S_UP_GOOD;
            end else begin
              rail_idx <= rail_idx + 1'b1;
              state    <= S_UP_EN;
            end
          end else if (expired) begin
            error    <= 1'b1;
            fail_idx <= rail_idx;
            state    <= S_DN_HOLD;
          end
        end
        S_UP_GOOD: begin
          if (expired) begin
            rst_n   <= 1'b1;
            powered <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_DN_HOLD: begin
          if (expired) begin
            all_good <= 1'b0;
            rail_idx <= LAST_IDX;
            state    <= S_DN_EN;
          end
        end
        S_DN_EN: begin
          en_log[rail_idx] <= 1'b0;
          state            <= S_DN_WAIT;
        end
        S_DN_WAIT: begin
          if (!pg_sel || expired) begin
            if (pg_sel) begin
              error <= 1'b1;
              if (!error) fail_idx <= rail_idx;
            end
            if (rail_idx == '0) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              rail_idx <= rail_idx - 1'b1;
              state    <= S_DN_EN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_RAIL_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(en_log ^ $past(en_log)) <= 1); // R1

  AST_GOOD_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    all_good |-> (&en_log)); // R4

  AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    rst_n |-> all_good); // R4

  AST_ERROR_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
    error |-> !rst_n); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(en_log)); // R9

  AST_FAIL_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    fail_idx <= LAST_IDX); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int                   NUM_RAILS    = 5,
  parameter int                   CLKS_PER_US  = 100,
  parameter int                   TIMEOUT_US   = 20000,
  parameter int                   RST_HOLD_US  = 5000,
  parameter int                   GOOD_WAIT_US = 1000,
  parameter logic [NUM_RAILS-1:0] INV_MASK     = 5'b00100,
  localparam int                  IDX_W        = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_on_req,
  input  logic                 pwr_off_req,
  input  logic [NUM_RAILS-1:0] rail_pg,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 rails_good,
  output logic                 dev_rst_n,
  output logic                 busy,
  output logic                 done,
  output logic                 error,
  output logic [IDX_W-1:0]     fail_rail
);

  localparam int MAX_US = max3(TIMEOUT_US, RST_HOLD_US, GOOD_WAIT_US);
  localparam int CNT_W  = $clog2(MAX_US + 1) + 1;

  logic [NUM_RAILS-1:0] en_log;
  logic [NUM_RAILS-1:0] pg_log;
  logic                 tmr_start;
  logic                 tmr_expired;
  logic [CNT_W-1:0]     tmr_limit;

  rail_pin_map #(
    .NUM_RAILS (NUM_RAILS),
    .INV_MASK  (INV_MASK)
  ) u_pins (
    .en_log (en_log),
    .pg_pin (rail_pg),
    .en_pin (rail_en),
    .pg_log (pg_log)
  );

  rail_us_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .limit   (tmr_limit),
    .expired (tmr_expired)
  );

  rail_seq_fsm #(
    .NUM_RAILS    (NUM_RAILS),
    .IDX_W        (IDX_W),
    .CNT_W        (CNT_W),
    .TIMEOUT_US   (TIMEOUT_US),
    .RST_HOLD_US  (RST_HOLD_US),
    .GOOD_WAIT_US (GOOD_WAIT_US)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .on_req    (pwr_on_req),
    .off_req   (pwr_off_req),
    .pg_log    (pg_log),
    .expired   (tmr_expired),
    .tmr_start (tmr_start),
    .tmr_limit (tmr_limit),
    .en_log    (en_log),
    .all_good  (rails_good),
    .rst_n     (dev_rst_n),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .fail_idx  (fail_rail)
  );

  AST_IDLE_PINS_OFF_AFTER_FAIL: assert property (@(posedge clk) disable iff (rst)
    (error && done) |-> (rail_en == INV_MASK)); // R5

endmodule

// File: tb/rail_seq_ctrl_test.sv
`timescale 1ns/1ps
module rail_seq_ctrl_test;

  localparam int N    = 5;
  localparam int CPU  = 2;
  localparam int TO   = 20;
  localparam int HOLD = 10;
  localparam int GOOD = 5;
  localparam logic [N-1:0] INV = 5'b00100;
  localparam int WD_LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pwr_on_req = 1'b0;
  logic         pwr_off_req = 1'b0;
  logic [N-1:0] rail_pg;
  logic [N-1:0] rail_en;
  logic         rails_good, dev_rst_n, busy, done, error;
  logic [2:0]   fail_rail;

  rail_seq_ctrl #(
    .NUM_RAILS (N), .CLKS_PER_US (CPU), .TIMEOUT_US (TO),
    .RST_HOLD_US (HOLD), .GOOD_WAIT_US (GOOD), .INV_MASK (INV)
  ) uut (
    .clk (clk), .rst (rst), .pwr_on_req (pwr_on_req), .pwr_off_req (pwr_off_req),
    .rail_pg (rail_pg), .rail_en (rail_en), .rails_good (rails_good),
    .dev_rst_n (dev_rst_n), .busy (busy), .done (done), .error (error),
    .fail_rail (fail_rail)
  );

  always #2.5 clk = ~clk;

  // regulator models: logical state follows the enable after a delay
  logic [N-1:0] reg_st = '0;
  logic [N-1:0] stuck = '0;
  int dly_on [N] = '{3, 7, 1, 5, 2};
  int dly_off[N] = '{2, 4, 6, 1, 3};
  int rcnt   [N] = '{0, 0, 0, 0, 0};
  assign rail_pg = reg_st ^ INV;

  always @(negedge clk) begin
    if (rst) begin
      reg_st = '0;
      for (int i = 0; i < N; i++) rcnt[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic tgt;
        tgt = rail_en[i] ^ INV[i];
        if (stuck[i]) rcnt[i] = 0;
        else if (reg_st[i] != tgt) begin
          rcnt[i]++;
          if (rcnt[i] >= (tgt ? dly_on[i] : dly_off[i])) begin
            reg_st[i] = tgt;
            rcnt[i] = 0;
          end
        end else rcnt[i] = 0;
      end
    end
  end

  // behavioural reference model, advanced on every rising edge
  int m_ph, m_rail, m_el, m_fail;
  logic [N-1:0] m_en;
  logic m_good, m_rstn, m_busy, m_done, m_err, m_pwr;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_rail = 0; m_el = 0; m_fail = 0; m_en = '0;
      m_good = 0; m_rstn = 0; m_busy = 0; m_done = 0; m_err = 0; m_pwr = 0;
    end else begin
      bit st, ex;
      int lim;
      logic [N-1:0] plg;
      st = 0;
      lim = (m_ph == 3) ? GOOD : (m_ph == 4) ? HOLD : TO;
      ex = (m_el >= lim * CPU);
      plg = rail_pg ^ INV;
      case (m_ph)
        0: if (pwr_on_req && !m_pwr) begin
             m_ph = 1; m_rail = 0; m_busy = 1; m_done = 0; m_err = 0; m_fail = 0; m_rstn = 0;
           end else if (pwr_off_req && m_pwr) begin
             m_ph = 4; m_busy = 1; m_done = 0; m_err = 0; m_fail = 0; m_rstn = 0; m_pwr = 0; st = 1;
           end
        1: begin m_en[m_rail] = 1; st = 1; m_ph = 2; end
        2: if (plg[m_rail]) begin
             if (m_rail == N-1) begin m_good = 1; st = 1; m_ph = 3; end
             else begin m_rail++; m_ph = 1; end
           end else if (ex) begin
             m_err = 1; m_fail = m_rail; st = 1; m_ph = 4;
           end
        3: if (ex) begin m_rstn = 1; m_pwr = 1; m_done = 1; m_busy = 0; m_ph = 0; end
        4: if (ex) begin m_good = 0; m_rail = N-1; m_ph = 5; end
        5: begin m_en[m_rail] = 0; st = 1; m_ph = 6; end
        6: if (!plg[m_rail] || ex) begin
             if (plg[m_rail]) begin
               if (!m_err) m_fail = m_rail;
               m_err = 1;
             end
             if (m_rail == 0) begin m_done = 1; m_busy = 0; m_ph = 0; end
             else begin m_rail--; m_ph = 5; end
           end
        default: m_ph = 0;
      endcase
      m_el = st ? 0 : m_el + 1;
    end
  end

  // scenario checks (initial block) and per-cycle checks (negedge block) keep separate counters
  int total = 0, bad = 0;
  int ctot = 0, cbad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor records and per-cycle comparison
  int rise_q[$];
  int fall_q[$];
  int rise_cyc[N];
  int good_rise = 0, good_fall = 0, rstn_rise = 0, rstn_fall = 0, err_rise = 0;
  int busy_falls = 0;
  bit saw_good = 0;
  logic [N-1:0] prev_l = '0;
  logic prev_good = 0, prev_rstn = 0, prev_err = 0, prev_busy = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst) begin
      logic [N-1:0] cur_l;
      cur_l = rail_en ^ INV;
      for (int i = 0; i < N; i++) begin
        if (cur_l[i] && !prev_l[i]) begin rise_q.push_back(i); rise_cyc[i] = cyc; end
        if (!cur_l[i] && prev_l[i]) fall_q.push_back(i);
      end
      if (rails_good && !prev_good) good_rise = cyc;
      if (!rails_good && prev_good) good_fall = cyc;
      if (dev_rst_n && !prev_rstn) rstn_rise = cyc;
      if (!dev_rst_n && prev_rstn) rstn_fall = cyc;
      if (error && !prev_err) err_rise = cyc;
      if (!busy && prev_busy) busy_falls++;
      if (rails_good) saw_good = 1;
      prev_l = cur_l; prev_good = rails_good; prev_rstn = dev_rst_n;
      prev_err = error; prev_busy = busy;

      ctot++;
      if (rail_en !== (m_en ^ INV)) begin
        cbad++; $display("FAIL R1 cycle %0d enables: actual=%0d expected=%0d", cyc, rail_en, m_en ^ INV);
      end
      ctot++;
      if (rails_good !== m_good || dev_rst_n !== m_rstn) begin
        cbad++; $display("FAIL R4 cycle %0d good/rst_n: actual=%0d expected=%0d", cyc,
                         {rails_good, dev_rst_n}, {m_good, m_rstn});
      end
      ctot++;
      if (busy !== m_busy) begin
        cbad++; $display("FAIL R9 cycle %0d busy: actual=%0d expected=%0d", cyc, busy, m_busy);
      end
      ctot++;
      if (error !== m_err || fail_rail !== 3'(m_fail)) begin
        cbad++; $display("FAIL R7 cycle %0d error/fail: actual=%0d expected=%0d", cyc,
                         {error, fail_rail}, {m_err, 3'(m_fail)});
      end
      ctot++;
      if (done !== m_done) begin
        cbad++; $display("FAIL R10 cycle %0d done: actual=%0d expected=%0d", cyc, done, m_done);
      end
    end
    if (cyc >= WD_LIMIT) begin
      cbad++; ctot++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total + ctot, bad + cbad);
      $finish;
    end
  end

  task automatic pulse_on();
    @(negedge clk) pwr_on_req = 1'b1;
    @(negedge clk) pwr_on_req = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk) pwr_off_req = 1'b1;
    @(negedge clk) pwr_off_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base, bf;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(rail_en == INV, "R11 rail_en in reset", rail_en, INV);
    chk({rails_good, dev_rst_n, busy, done, error} == 5'b0, "R11 flags in reset",
        {rails_good, dev_rst_n, busy, done, error}, 0);
    chk(fail_rail == 0, "R11 fail_rail in reset", fail_rail, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R8: power-off ignored while not powered
    pulse_off();
    repeat (20) @(negedge clk);
    chk(busy == 0 && rail_en == INV, "R8 off ignored when unpowered", {busy, rail_en}, INV);

    // normal power-up, with stray requests while busy (R9)
    base = rise_q.size(); bf = busy_falls;
    pulse_on();
    chk(busy == 1 && dev_rst_n == 0, "R4 accept asserts reset, busy high", {busy, dev_rst_n}, 2);
    repeat (30) @(negedge clk);
    pulse_off();
    pulse_on();
    wait_idle();
    for (int k = 0; k < N; k++)
      chk(rise_q.size() > base + k && rise_q[base + k] == k, "R1 power-up order",
          (rise_q.size() > base + k) ? rise_q[base + k] : -1, k);
    chk(rail_en == 5'b11011, "R3 pins when all on", rail_en, 5'b11011);
    chk(rails_good && dev_rst_n && done && !error, "R4 powered up", {rails_good, dev_rst_n, done, error}, 4'b1110);
    chk(rstn_rise - good_rise == GOOD * CPU + 1, "R4 reset release delay", rstn_rise - good_rise, GOOD * CPU + 1);
    chk(busy_falls - bf == 1, "R9 busy falls once", busy_falls - bf, 1);

    // R8: power-on ignored while powered
    pulse_on();
    repeat (20) @(negedge clk);
    chk(!busy && dev_rst_n && done, "R8 on ignored when powered", {busy, dev_rst_n, done}, 3'b011);

    // normal power-down
    base = fall_q.size();
    pulse_off();
    wait_idle();
    for (int k = 0; k < N; k++)
      chk(fall_q.size() > base + k && fall_q[base + k] == N - 1 - k, "R6 power-down order",
          (fall_q.size() > base + k) ? fall_q[base + k] : -1, N - 1 - k);
    chk(good_fall - rstn_fall == HOLD * CPU + 1, "R6 hold before good drops", good_fall - rstn_fall, HOLD * CPU + 1);
    chk(rail_en == INV && !dev_rst_n && !rails_good && done && !error, "R6 all off",
        {rail_en, dev_rst_n, rails_good}, {INV, 2'b00});

    // rail 3 never comes up: timeout and rollback
    stuck[3] = 1'b1;
    saw_good = 0;
    pulse_on();
    wait_idle();
    chk(error && fail_rail == 3, "R5 failed rail index", fail_rail, 3);
    chk(err_rise - rise_cyc[3] == TO * CPU + 1, "R2 timeout length", err_rise - rise_cyc[3], TO * CPU + 1);
    chk(rail_en == INV && !dev_rst_n && !saw_good && done, "R5 rolled back, no good/release",
        {rail_en, dev_rst_n, saw_good}, {INV, 2'b00});
    pulse_off();
    repeat (20) @(negedge clk);
    chk(!busy, "R8 off ignored after failed power-up", busy, 0);
    stuck[3] = 1'b0;

    // inverted rail stuck: fail on rail 2, and R10 clearing on acceptance
    stuck[2] = 1'b1;
    pulse_on();
    chk(!error && fail_rail == 0 && !done, "R10 flags cleared on accept", {error, fail_rail, done}, 0);
    wait_idle();
    chk(error && fail_rail == 2, "R3 inverted rail timeout", fail_rail, 2);
    stuck[2] = 1'b0;
    repeat (10) @(negedge clk);

    // power-down with rails 3 and 1 refusing to turn off
    pulse_on();
    wait_idle();
    chk(dev_rst_n && !error, "R4 powered before stuck-off test", {dev_rst_n, error}, 2);
    stuck[3] = 1'b1; stuck[1] = 1'b1;
    base = fall_q.size();
    pulse_off();
    wait_idle();
    chk(error && fail_rail == 3, "R7 first failed rail kept", fail_rail, 3);
    chk(rail_en == INV && done && !busy, "R7 sequencing continued", rail_en, INV);
    chk(fall_q.size() - base == N, "R7 every rail disabled", fall_q.size() - base, N);
    stuck = '0;
    repeat (20) @(negedge clk);

    // R10: new sequence after error succeeds and clears flags
    pulse_on();
    chk(!error && fail_rail == 0, "R10 cleared at restart", {error, fail_rail}, 0);
    wait_idle();
    chk(done && !error && dev_rst_n, "R10 clean power-up after error", {done, error, dev_rst_n}, 3'b101);

    $display("  test done: total=%0d bad=%0d", total + ctot, bad + cbad);
    $finish;
  end

endmodule